// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Priority Controller

This block decides which of a fixed set of interrupt vectors is offered to a processor core, and keeps track of the handlers that are already running so that nesting follows the priority rules. Each vector has a request line, which is a flag already latched by its source, and an enable bit. It also has one level-select bit that places the vector either at the base level or at its elevated level. Only the first two vectors can be elevated to the top level. Every other vector is elevated to the middle level. Several sources may share one request line, since the OR of their flags can be wired to it.

The winner is found combinationally from the inputs and the in-service state. The outputs are a request to the core, the vector address and the level of the winner. When the core acknowledges an offered request, the level of the winner is recorded as in service on that same clock edge. A return-from-interrupt strobe removes the most recent, highest, in-service level. While a handler runs, only a vector at a strictly higher level can interrupt it.

Top module: `prio_vec_ctrl`

## Requirements
- R1: After reset `irq_o` is 0 and `in_svc_o` is 3'b000.
- R2: The vector address is 8'h03 + 8 × index, so vector 0 gives 8'h03 and vector 9 gives 8'h4B. The address is valid while `irq_o` is 1.
- R3: A `lvl_sel_i` bit of 0 puts a vector at the low level (code 0). A bit of 1 puts vectors 0 and 1 at the highest level (code 2) and vectors 2 to 9 at the high level (code 1). `vec_lvl_o` carries this code.
- R4: A request whose `en_i` bit is 0 is never offered and never changes which vector wins.
- R5: Among offered candidates, one at a higher level always wins over one at a lower level, whatever their indices.
- R6: Among candidates at the same level, the one with the lowest index (lowest address) wins.
- R7: When the highest set `in_svc_o` bit is level L, a request at level L or below is not offered and only a strictly higher level raises `irq_o`. When `in_svc_o[2]` is set, nothing is offered.
- R8: `ack_i` in a cycle with `irq_o` high sets the `in_svc_o` bit of the winning level at that clock edge. Bit 0 is low, bit 1 is high and bit 2 is highest. `ack_i` while `irq_o` is low has no effect.
- R9: `reti_i` clears the highest set `in_svc_o` bit and leaves the lower bits alone. When no bit is set it has no effect.
- R10: When `reti_i` and an effective `ack_i` fall in the same cycle, the highest old bit is cleared and the winner's bit is set, both at that edge.
- R11: `irq_o`, `vec_addr_o` and `vec_lvl_o` follow changes of `req_i`, `en_i` and `lvl_sel_i` in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 10 | Latched request flag per vector |
| en_i | input | 10 | Per-vector enable |
| lvl_sel_i | input | 10 | Per-vector level select (0 base, 1 elevated) |
| ack_i | input | 1 | Core takes the offered vector |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the core |
| vec_addr_o | output | 8 | Address of the winning vector |
| vec_lvl_o | output | 2 | Level code of the winning vector |
| in_svc_o | output | 3 | In-service bits per level |

## Verification
The arbitration is tried with several request sets and the in-service state empty. These cover a single request at either end of the vector range, two requests at one level, and requests at mixed levels where the higher-indexed vector holds the higher level. They also include elevated vectors on both sides of the top-capable boundary and requests that are masked by a cleared enable. Between them these patterns separate priority by level from priority by index, and they show whether the enable mask is applied. A nesting sequence then acknowledges three levels one over another. It tries equal and lower requests at each depth, unwinds with return strobes, and hits a return and an acknowledge in the same cycle, a return with nothing in service, and an acknowledge with nothing offered. These steps separate correct refusal from a stack that loses or skips levels.

// File: rtl/vic_pkg.sv
package vic_pkg;
   localparam int NUM_LVL = 3;
   localparam int LVL_W   = 2;

   typedef enum logic [LVL_W-1:0] {
      LV_LOW  = 2'd0,
      LV_HIGH = 2'd1,
      LV_TOP  = 2'd2
   } prio_lvl_e;
endpackage

// File: rtl/vic_level_map.sv
module vic_level_map
   import vic_pkg::*;
#(
   parameter int NUM_VEC     = 10,
   parameter int TOP_CAPABLE = 2
) (
   input  logic [NUM_VEC-1:0]            sel_i,
   output logic [NUM_VEC-1:0][LVL_W-1:0] lvl_o
);
   if (TOP_CAPABLE > NUM_VEC) begin : g_bad_top
      $error("TOP_CAPABLE exceeds NUM_VEC");
   end

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      if (v < TOP_CAPABLE) begin : g_top_ok
         assign lvl_o[v] = sel_i[v] ? LV_TOP : LV_LOW;
      end else begin : g_mid_only
         assign lvl_o[v] = sel_i[v] ? LV_HIGH : LV_LOW;
      end
   end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
   import vic_pkg::*;
#(
   parameter int NUM_VEC = 10,
   parameter int IDX_W   = $clog2(NUM_VEC)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_VEC-1:0]            cand_i,
   input  logic [NUM_VEC-1:0][LVL_W-1:0] lvl_i,
   input  logic [NUM_LVL-1:0]            svc_i,
   output logic                          hit_o,
   output logic [IDX_W-1:0]              win_idx_o,
   output logic [LVL_W-1:0]              win_lvl_o
);
   logic [NUM_LVL-1:0]            lv_found;
   logic [NUM_LVL-1:0][IDX_W-1:0] lv_idx;
   logic                          block_all;
   logic [LVL_W-1:0]              need_min;

   // Lowest-index candidate for each level
   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      logic             found;
      logic [IDX_W-1:0] idx;
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = NUM_VEC-1; i >= 0; i--) begin
            if (cand_i[i] && (lvl_i[i] == LVL_W'(g))) begin
               found = 1'b1;
               idx   = IDX_W'(i);
            end
         end
      end
      assign lv_found[g] = found;
      assign lv_idx[g]   = idx;
   end

   // Nesting floor from the in-service stack
   always_comb begin
      block_all = 1'b0;
      need_min  = LV_LOW;
      if (svc_i[2])      block_all = 1'b1;
      else if (svc_i[1]) need_min  = LV_TOP;
      else if (svc_i[0]) need_min  = LV_HIGH;
   end

   // Highest allowed level wins; ascending scan keeps the last one
   always_comb begin
      hit_o     = 1'b0;
      win_idx_o = '0;
      win_lvl_o = LV_LOW;
      for (int l = 0; l < NUM_LVL; l++) begin
         if (lv_found[l] && !block_all && (LVL_W'(l) >= need_min)) begin
            hit_o     = 1'b1;
            win_idx_o = lv_idx[l];
            win_lvl_o = LVL_W'(l);
         end
      end
   end

   // R4: the offered vector is a real candidate at the reported level
   p_win_is_candidate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> (cand_i[win_idx_o] && (lvl_i[win_idx_o] == win_lvl_o)));

   // R7: nothing offered while the top level is in service
   p_top_blocks_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
      svc_i[2] |-> !hit_o);
endmodule

// File: rtl/vic_service_stack.sv
module vic_service_stack
   import vic_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push_i,
   input  logic [LVL_W-1:0]   push_lvl_i,
   input  logic               pop_i,
   output logic [NUM_LVL-1:0] svc_o
);
   logic [NUM_LVL-1:0] svc_q;
   logic [NUM_LVL-1:0] popped;
   logic [NUM_LVL-1:0] svc_d;

   always_comb begin
      popped = svc_q;
      if (pop_i) begin
         for (int l = 0; l < NUM_LVL; l++) begin
            if (svc_q[l]) popped = svc_q & ~(NUM_LVL'(1) << l);
         end
      end
      svc_d = popped;
      if (push_i) svc_d = popped | (NUM_LVL'(1) << push_lvl_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) svc_q <= '0;
      else        svc_q <= svc_d;
   end

   assign svc_o = svc_q;

   // R8: a push leaves its level marked in service
   p_push_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> svc_q[$past(push_lvl_i)]);

   // R9: a lone pop removes exactly one level
   p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && (svc_q != '0)) |=>
         ($countones(svc_q) == $countones($past(svc_q)) - 1));

   // R9: pop on an empty stack keeps it empty
   p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && (svc_q == '0)) |=> (svc_q == '0));

   // R7: a push only ever lands above every level already in service
   p_push_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> ((svc_q >> push_lvl_i) == '0));
endmodule

// File: rtl/prio_vec_ctrl.sv
module prio_vec_ctrl
   import vic_pkg::*;
#(
   parameter int NUM_VEC     = 10,
   parameter int ADDR_W      = 8,
   parameter int VEC_BASE    = 3,
   parameter int VEC_STRIDE  = 8,
   parameter int TOP_CAPABLE = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] req_i,
   input  logic [NUM_VEC-1:0] en_i,
   input  logic [NUM_VEC-1:0] lvl_sel_i,
   input  logic               ack_i,
   input  logic               reti_i,
   output logic               irq_o,
   output logic [ADDR_W-1:0]  vec_addr_o,
   output logic [LVL_W-1:0]   vec_lvl_o,
   output logic [NUM_LVL-1:0] in_svc_o
);
   localparam int IDX_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
   localparam int LAST_ADR = VEC_BASE + (NUM_VEC - 1) * VEC_STRIDE;

   if (NUM_VEC < 2) begin : g_bad_num
      $error("NUM_VEC must be at least 2");
   end
   if (LAST_ADR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("vector addresses do not fit ADDR_W");
   end

   logic [NUM_VEC-1:0][LVL_W-1:0] vec_lvl;
   logic [NUM_VEC-1:0]            cand;
   logic                          hit;
   logic [IDX_W-1:0]              win_idx;
   logic [LVL_W-1:0]              win_lvl;
   logic [NUM_LVL-1:0]            svc;

   assign cand = req_i & en_i;

   vic_level_map #(.NUM_VEC(NUM_VEC), .TOP_CAPABLE(TOP_CAPABLE)) u_map (
      .sel_i (lvl_sel_i),
      .lvl_o (vec_lvl)
   );

   vic_arbiter #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .cand_i    (cand),
      .lvl_i     (vec_lvl),
      .svc_i     (svc),
      .hit_o     (hit),
      .win_idx_o (win_idx),
      .win_lvl_o (win_lvl)
   );

   vic_service_stack u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (ack_i && hit),
      .push_lvl_i (win_lvl),
      .pop_i      (reti_i),
      .svc_o      (svc)
   );

   assign irq_o      = hit;
   assign vec_lvl_o  = win_lvl;
   assign vec_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(win_idx) * ADDR_W'(VEC_STRIDE);
   assign in_svc_o   = svc;

   // R4: a request reaches the core only through an enabled line
   p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((req_i & en_i) != '0));

   // R3: the top level is reachable only by the top-capable vectors
   p_top_only_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && (vec_lvl_o == LV_TOP)) |-> (int'(win_idx) < TOP_CAPABLE));

   // R7: an offered level is strictly above every level in service
   p_strictly_above_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((in_svc_o >> vec_lvl_o) == '0));

   // R8: an acknowledge without an offer leaves the stack as it was
   p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_o && !reti_i) |=> $stable(in_svc_o));
endmodule

// File: tb/prio_vec_ctrl_bench.sv
module prio_vec_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] req = '0, en = '0, sel = '0;
   logic       ack = 1'b0, reti = 1'b0;
   logic       irq;
   logic [7:0] addr;
   logic [1:0] lvl;
   logic [2:0] svc;
   int         total = 0;
   int         bad = 0;

   always #10 clk = ~clk;

   prio_vec_ctrl u_prio_vec_ctrl (
      .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .lvl_sel_i(sel),
      .ack_i(ack), .reti_i(reti), .irq_o(irq), .vec_addr_o(addr),
      .vec_lvl_o(lvl), .in_svc_o(svc)
   );

   // {en, sel, req, irq, addr, lvl}
   localparam int NROW = 11;
   localparam logic [40:0] TBL [NROW] = '{
      {10'h3FF, 10'h000, 10'h000, 1'b0, 8'h00, 2'd0},  // R4 nothing requested
      {10'h3FF, 10'h000, 10'h020, 1'b1, 8'h2B, 2'd0},  // R2 vector 5
      {10'h3FF, 10'h000, 10'h200, 1'b1, 8'h4B, 2'd0},  // R2 vector 9
      {10'h3FF, 10'h000, 10'h088, 1'b1, 8'h1B, 2'd0},  // R6 3 and 7 low
      {10'h3FF, 10'h080, 10'h088, 1'b1, 8'h3B, 2'd1},  // R5 7 high over 3 low
      {10'h3FF, 10'h012, 10'h012, 1'b1, 8'h0B, 2'd2},  // R3 R5 1 top over 4 high
      {10'h3FF, 10'h003, 10'h003, 1'b1, 8'h03, 2'd2},  // R6 0 and 1 both top
      {10'h3BF, 10'h000, 10'h040, 1'b0, 8'h00, 2'd0},  // R4 vector 6 masked
      {10'h3FB, 10'h000, 10'h104, 1'b1, 8'h43, 2'd0},  // R4 2 masked, 8 wins
      {10'h3FF, 10'h004, 10'h004, 1'b1, 8'h13, 2'd1},  // R3 vector 2 only high
      {10'h3FF, 10'h200, 10'h201, 1'b1, 8'h4B, 2'd1}   // R5 9 high over 0 low
   };

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic drive(input logic [9:0] e, input logic [9:0] s, input logic [9:0] r);
      @(negedge clk);
      en = e; sel = s; req = r;
      #2;
   endtask

   task automatic pulse(input logic a, input logic r);
      @(negedge clk);
      ack = a; reti = r;
      @(posedge clk);
      #2;
      ack = 1'b0; reti = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #5;
      check("R1 irq in reset", 32'(irq), 32'd0);
      check("R1 in_svc in reset", 32'(svc), 32'd0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 in_svc after reset", 32'(svc), 32'd0);

      // R11: outputs follow the inputs combinationally in each table row
      for (int k = 0; k < NROW; k++) begin
         drive(TBL[k][40:31], TBL[k][30:21], TBL[k][20:11]);
         check($sformatf("R11 table row %0d irq", k), 32'(irq), 32'(TBL[k][10]));
         if (TBL[k][10]) begin
            check($sformatf("R2 table row %0d addr", k), 32'(addr), 32'(TBL[k][9:2]));
            check($sformatf("R5 R6 table row %0d level", k), 32'(lvl), 32'(TBL[k][1:0]));
         end
      end

      // R8: acknowledge with nothing offered changes nothing
      drive(10'h3FF, 10'h000, 10'h000);
      pulse(1'b1, 1'b0);
      check("R8 idle ack", 32'(svc), 32'd0);

      // R9: return with an empty stack
      pulse(1'b0, 1'b1);
      check("R9 empty reti", 32'(svc), 32'd0);

      // Nesting: low handler enters
      drive(10'h3FF, 10'h000, 10'h010);
      pulse(1'b1, 1'b0);
      check("R8 low pushed", 32'(svc), 32'b001);
      check("R7 same low refused", 32'(irq), 32'd0);
      drive(10'h3FF, 10'h000, 10'h030);
      check("R7 other low refused", 32'(irq), 32'd0);
      drive(10'h3FF, 10'h020, 10'h030);
      check("R7 high nests over low", 32'(irq), 32'd1);
      check("R7 high vector addr", 32'(addr), 32'h2B);
      pulse(1'b1, 1'b0);
      check("R8 high pushed", 32'(svc), 32'b011);
      drive(10'h3FF, 10'h060, 10'h070);
      check("R7 high refused under high", 32'(irq), 32'd0);
      drive(10'h3FF, 10'h061, 10'h071);
      check("R7 top nests over high", 32'(irq), 32'd1);
      check("R3 top vector level", 32'(lvl), 32'd2);
      check("R2 top vector addr", 32'(addr), 32'h03);
      pulse(1'b1, 1'b0);
      check("R8 top pushed", 32'(svc), 32'b111);
      drive(10'h3FF, 10'h3FF, 10'h3FF);
      check("R7 all refused under top", 32'(irq), 32'd0);

      // Unwind
      drive(10'h3FF, 10'h001, 10'h001);
      pulse(1'b0, 1'b1);
      check("R9 pop top", 32'(svc), 32'b011);
      pulse(1'b0, 1'b1);
      check("R9 pop high", 32'(svc), 32'b001);
      check("R7 top offered over low", 32'(irq), 32'd1);
      pulse(1'b1, 1'b1);
      check("R10 pop and push together", 32'(svc), 32'b100);
      pulse(1'b0, 1'b1);
      check("R9 pop to empty", 32'(svc), 32'b000);

      // R4: enable cleared after request stays ignored at the stack too
      drive(10'h000, 10'h000, 10'h3FF);
      check("R4 all masked", 32'(irq), 32'd0);
      pulse(1'b1, 1'b0);
      check("R4 masked ack no push", 32'(svc), 32'b000);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule